// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the time of day and the calendar as seven byte-wide BCD registers: seconds, minutes, hours, day of month, month, weekday and a two-digit year. A single-cycle pulse on the one-second tick input moves the whole chain forward by one second. The carries ripple through the fields in one clock, so a tick at 23:59:59 on the last day of a year rolls every field at the same edge. Month lengths and February in leap years are handled. The hours field can run as a 24-hour count, or as a 12-hour count that carries an afternoon flag.

A host sets the time through a parallel write port that addresses one register per cycle. It reads the time back through a registered parallel read port. Bit 7 of the seconds register is a stop bit: while it is 1, ticks are dropped and every register keeps its value. The oscillator, the divider down to one hertz and any serial host link sit outside the block.

Top module: `bcd_timekeeper`

## Requirements
- R1: Seconds and minutes count in BCD from 0x00 to 0x59. On the tick that takes a field from 0x59 back to 0x00, a carry passes into the next field up.
- R2: When hours bit 7 is 0, hours run from 0x00 to 0x23. The step from 0x23 to 0x00 moves the day of month and the weekday forward by one.
- R3: When hours bit 7 is 1, bits 4:0 hold the hour 01–12 in BCD and bit 5 is the afternoon flag. The order is 0x91 → 0xB2 → 0xA1 and 0xB1 → 0x92. The step from 0xB1 to 0x92 moves the date forward. The step from 0xB2 to 0xA1 keeps the flag set.
- R4: The weekday (selector 5) counts 1 to 7 and goes back to 1 on each day change.
- R5: After day 31 of months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12, and after day 30 of months 0x04, 0x06, 0x09 and 0x11, the date returns to 0x01 and the month moves forward.
- R6: In February the date wraps after day 0x29 when the year is a multiple of four (0x00 counts as one). In all other years it wraps after day 0x28.
- R7: The month counts from 0x01 to 0x12 and then moves the year forward. The year counts from 0x00 to 0x99 and then returns to 0x00.
- R8: While seconds bit 7 is 1, ticks are ignored and all seven registers keep their values.
- R9: A write in the same cycle as a tick stores the written value, and that tick is discarded for every register.
- R10: Bits with no meaning always read as 0: minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5 and weekday bits 7:3. A write of 0xFF therefore reads back as 0x7F, 0xBF, 0x3F, 0x1F and 0x07 in those fields.
- R11: The read port is registered. rd_data shows the register chosen by rd_sel one clock later. Selectors are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year. Selector 7 reads 0x00, and writes to selector 7 have no effect.
- R12: After reset the registers read seconds 0x00 (running), minutes 0x00, hours 0x00 (24-hour), date 0x01, month 0x01, weekday 0x01 and year 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, one per second |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Register selector for a write |
| wr_data | input | 8 | Write value |
| rd_sel | input | 3 | Register selector for a read |
| rd_data | output | 8 | Registered read value |

## Verification
A tick or a write changes the registers at the clock edge where it is sampled. The read port adds one more edge. So any result is first visible on rd_data two edges after its stimulus is applied. The bench drives every input on a falling edge and places the next read selector there as well. It samples rd_data on the second falling edge after that. The bench does not read again until the read back of all seven registers has finished. Each comparison is made against a calendar model in the bench, which is stepped once for each tick that is not dropped.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    F_SEC   = 3'd0,
    F_MIN   = 3'd1,
    F_HOUR  = 3'd2,
    F_DATE  = 3'd3,
    F_MONTH = 3'd4,
    F_DOW   = 3'd5,
    F_YEAR  = 3'd6,
    F_GAP   = 3'd7
  } field_e;

  // writable bits per field
  localparam logic [REG_W-1:0] MASK_SEC   = 8'h7F;
  localparam logic [REG_W-1:0] MASK_MIN   = 8'h7F;
  localparam logic [REG_W-1:0] MASK_HOUR  = 8'hBF;
  localparam logic [REG_W-1:0] MASK_DATE  = 8'h3F;
  localparam logic [REG_W-1:0] MASK_MONTH = 8'h1F;
  localparam logic [REG_W-1:0] MASK_DOW   = 8'h07;
  localparam logic [REG_W-1:0] MASK_YEAR  = 8'hFF;

  // two-digit BCD increment, no range limit
  function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction
endpackage

// File: rtl/tk_bcd_pair.sv
module tk_bcd_pair #(
  parameter int REG_W = tk_pkg::REG_W,
  parameter logic [REG_W-1:0] RST_VAL = '0,
  parameter logic [REG_W-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             ld,
  input  logic [REG_W-1:0] ld_val,
  input  logic [REG_W-1:0] lo,
  input  logic [REG_W-1:0] hi,
  output logic [REG_W-1:0] q,
  output logic             wrap_o
);
  logic [REG_W-1:0] nxt;

  always_comb begin
    if (q == hi) nxt = lo;
    else         nxt = tk_pkg::bcd_inc(q);
  end

  assign wrap_o = inc && !ld && (q == hi);

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (ld)  q <= ld_val & MASK;
    else if (inc) q <= nxt;
  end

  // R1/R7: a field at its top value returns to its bottom value on a step
  p_wrap_to_low_r1: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && q == hi) |=> (q == $past(lo)));
  // R1: an untouched field holds
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld) |=> $stable(q));
endmodule

// File: rtl/tk_hour_unit.sv
module tk_hour_unit #(
  parameter int REG_W = tk_pkg::REG_W,
  parameter logic [REG_W-1:0] MASK = tk_pkg::MASK_HOUR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             ld,
  input  logic [REG_W-1:0] ld_val,
  output logic [REG_W-1:0] q,
  output logic             day_o
);
  localparam logic [4:0] H11 = 5'h11;
  localparam logic [4:0] H12 = 5'h12;
  localparam logic [5:0] H23 = 6'h23;

  logic       mode12;
  logic       pm;
  logic [4:0] h12;
  logic [REG_W-1:0] nxt;

  assign mode12 = q[7];
  assign pm     = q[5];
  assign h12    = q[4:0];

  always_comb begin
    nxt   = q;
    day_o = 1'b0;
    if (mode12) begin
      if (h12 == H12) begin
        nxt = {1'b1, 1'b0, pm, 5'h01};
      end else if (h12 == H11) begin
        nxt   = {1'b1, 1'b0, ~pm, H12};
        day_o = pm;
      end else begin
        nxt = {1'b1, 1'b0, pm, tk_pkg::bcd_inc({3'b000, h12})};
        nxt[7:5] = {1'b1, 1'b0, pm};
      end
    end else begin
      if (q[5:0] == H23) begin
        nxt   = 8'h00;
        day_o = 1'b1;
      end else begin
        nxt = tk_pkg::bcd_inc({2'b00, q[5:0]});
      end
    end
    day_o = day_o && inc && !ld;
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val & MASK;
    else if (inc) q <= nxt;
  end

  // R2: midnight in 24-hour mode
  p_midnight24_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && q == 8'h23) |=> (q == 8'h00));
  // R3: 11 PM steps to 12 AM, 11 AM to 12 PM, 12 PM to 1 PM
  p_midnight12_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && q == 8'hB1) |=> (q == 8'h92));
  p_noon12_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && q == 8'h91) |=> (q == 8'hB2));
  p_one_pm_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && q == 8'hB2) |=> (q == 8'hA1));
  // R2/R3: a day change comes only from the last hour of the day
  p_day_src_r2: assert property (@(posedge clk) disable iff (rst)
    day_o |-> (q == 8'h23 || q == 8'hB1));
endmodule

// File: rtl/tk_month_days.sv
module tk_month_days #(
  parameter int REG_W = tk_pkg::REG_W
) (
  input  logic [REG_W-1:0] month,
  input  logic [REG_W-1:0] year,
  output logic [REG_W-1:0] last_day
);
  logic       leap;
  logic [1:0] mod4;

  // 10 = 2 (mod 4): year mod 4 = ones + 2*tens
  assign mod4 = year[1:0] + {year[4], 1'b0};
  assign leap = (mod4 == 2'd0);

  always_comb begin
    case (month[4:0])
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper #(
  parameter int REG_W = tk_pkg::REG_W,
  parameter int SEL_W = tk_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_1hz,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_data
);
  import tk_pkg::*;

  localparam logic [REG_W-1:0] V00 = 8'h00;
  localparam logic [REG_W-1:0] V01 = 8'h01;
  localparam logic [REG_W-1:0] V07 = 8'h07;
  localparam logic [REG_W-1:0] V12 = 8'h12;
  localparam logic [REG_W-1:0] V59 = 8'h59;
  localparam logic [REG_W-1:0] V99 = 8'h99;

  logic halt_q;
  logic step;
  logic [REG_W-1:0] sec_q, min_q, hour_q, date_q, mon_q, dow_q, year_q;
  logic [REG_W-1:0] last_day;
  logic sec_wrap, min_wrap, day_adv, date_wrap, mon_wrap;
  logic year_wrap, dow_wrap;
  logic ld_sec, ld_min, ld_hour, ld_date, ld_mon, ld_dow, ld_year;

  assign step = tick_1hz && !halt_q && !wr_en;

  assign ld_sec  = wr_en && (wr_sel == F_SEC);
  assign ld_min  = wr_en && (wr_sel == F_MIN);
  assign ld_hour = wr_en && (wr_sel == F_HOUR);
  assign ld_date = wr_en && (wr_sel == F_DATE);
  assign ld_mon  = wr_en && (wr_sel == F_MONTH);
  assign ld_dow  = wr_en && (wr_sel == F_DOW);
  assign ld_year = wr_en && (wr_sel == F_YEAR);

  always_ff @(posedge clk) begin
    if (rst)         halt_q <= 1'b0;
    else if (ld_sec) halt_q <= wr_data[7];
  end

  tk_bcd_pair #(.REG_W(REG_W), .RST_VAL(V00), .MASK(MASK_SEC)) u_sec (
    .clk(clk), .rst(rst), .inc(step), .ld(ld_sec), .ld_val(wr_data),
    .lo(V00), .hi(V59), .q(sec_q), .wrap_o(sec_wrap));

  tk_bcd_pair #(.REG_W(REG_W), .RST_VAL(V00), .MASK(MASK_MIN)) u_min (
    .clk(clk), .rst(rst), .inc(sec_wrap), .ld(ld_min), .ld_val(wr_data),
    .lo(V00), .hi(V59), .q(min_q), .wrap_o(min_wrap));

  tk_hour_unit #(.REG_W(REG_W), .MASK(MASK_HOUR)) u_hour (
    .clk(clk), .rst(rst), .inc(min_wrap), .ld(ld_hour), .ld_val(wr_data),
    .q(hour_q), .day_o(day_adv));

  tk_month_days #(.REG_W(REG_W)) u_mdays (
    .month(mon_q), .year(year_q), .last_day(last_day));

  tk_bcd_pair #(.REG_W(REG_W), .RST_VAL(V01), .MASK(MASK_DATE)) u_date (
    .clk(clk), .rst(rst), .inc(day_adv), .ld(ld_date), .ld_val(wr_data),
    .lo(V01), .hi(last_day), .q(date_q), .wrap_o(date_wrap));

  tk_bcd_pair #(.REG_W(REG_W), .RST_VAL(V01), .MASK(MASK_DOW)) u_dow (
    .clk(clk), .rst(rst), .inc(day_adv), .ld(ld_dow), .ld_val(wr_data),
    .lo(V01), .hi(V07), .q(dow_q), .wrap_o(dow_wrap));

  tk_bcd_pair #(.REG_W(REG_W), .RST_VAL(V01), .MASK(MASK_MONTH)) u_mon (
    .clk(clk), .rst(rst), .inc(date_wrap), .ld(ld_mon), .ld_val(wr_data),
    .lo(V01), .hi(V12), .q(mon_q), .wrap_o(mon_wrap));

  tk_bcd_pair #(.REG_W(REG_W), .RST_VAL(V00), .MASK(MASK_YEAR)) u_year (
    .clk(clk), .rst(rst), .inc(mon_wrap), .ld(ld_year), .ld_val(wr_data),
    .lo(V00), .hi(V99), .q(year_q), .wrap_o(year_wrap));

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_sel)
        F_SEC:   rd_data <= {halt_q, sec_q[6:0]};
        F_MIN:   rd_data <= min_q;
        F_HOUR:  rd_data <= hour_q;
        F_DATE:  rd_data <= date_q;
        F_MONTH: rd_data <= mon_q;
        F_DOW:   rd_data <= dow_q;
        F_YEAR:  rd_data <= year_q;
        default: rd_data <= '0;
      endcase
    end
  end

  // R8: stopped chain holds every register
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
                            $stable(date_q) && $stable(mon_q) && $stable(dow_q) &&
                            $stable(year_q)));
  // R9: a write wins over a tick in the same cycle
  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == F_MIN && tick_1hz) |=> (min_q == ($past(wr_data) & MASK_MIN) &&
                                               $stable(sec_q)));
  // R10: unused date bits read 0
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == F_DATE) |=> (rd_data[7:6] == 2'b00));
  // R11: gap selector reads 0
  p_gap_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == F_GAP) |=> (rd_data == '0));
  // R4: weekday wraps to 1 on a day change from 7
  p_dow_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (day_adv && dow_q == V07) |=> (dow_q == V01));
  // R7: year rolls from 99 to 00 only on a month carry
  p_year_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    year_wrap |=> (year_q == V00 && mon_q == V01));
endmodule

// File: tb/tb_bcd_timekeeper.sv
module tb_bcd_timekeeper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state (binary)
  int m_s, m_m, m_h, m_dt, m_mo, m_dw, m_yr;
  bit m_12, m_halt;

  always #2 clk = ~clk;

  bcd_timekeeper dut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data));

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int unbcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_enc(input int h, input bit t12);
    int hh;
    if (!t12) return bcd(h);
    hh = (h % 12 == 0) ? 12 : h % 12;
    return 8'h80 | ((h >= 12) ? 8'h20 : 8'h00) | bcd(hh);
  endfunction

  function automatic logic [7:0] enc(input int sel);
    case (sel)
      0: return {m_halt, bcd(m_s)[6:0]};
      1: return bcd(m_m);
      2: return hour_enc(m_h, m_12);
      3: return bcd(m_dt);
      4: return bcd(m_mo);
      5: return bcd(m_dw);
      6: return bcd(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_tick();
    if (m_halt) return;
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_m++;
    if (m_m < 60) return;
    m_m = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0;
    m_dw = (m_dw == 7) ? 1 : m_dw + 1;
    m_dt++;
    if (m_dt <= mlen(m_mo, m_yr)) return;
    m_dt = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1;
    m_yr = (m_yr == 99) ? 0 : m_yr + 1;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // call at a negedge; returns at a negedge
  task automatic rd(input int sel, output logic [7:0] v);
    rd_sel = 3'(sel);
    @(negedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 7; i++) begin
      rd(i, v);
      chk($sformatf("%s field%0d", tag, i), v, enc(i));
    end
  endtask

  task automatic wr(input int sel, input logic [7:0] d, input bit with_tick);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d; tick_1hz = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
  endtask

  task automatic tick();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    model_tick();
  endtask

  task automatic load(input int s, input int m, input int h, input bit t12,
                      input int dt, input int mo, input int dw, input int yr);
    m_m = m; m_h = h; m_12 = t12; m_dt = dt; m_mo = mo; m_dw = dw; m_yr = yr;
    m_s = s; m_halt = 0;
    wr(1, bcd(m), 0);
    wr(2, hour_enc(h, t12), 0);
    wr(3, bcd(dt), 0);
    wr(4, bcd(mo), 0);
    wr(5, bcd(dw), 0);
    wr(6, bcd(yr), 0);
    wr(0, bcd(s), 0);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    m_s = 0; m_m = 0; m_h = 0; m_12 = 0; m_dt = 1; m_mo = 1; m_dw = 1; m_yr = 0; m_halt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R12 reset");

    // R1 seconds/minutes carry
    load(59, 59, 5, 0, 10, 6, 3, 21);
    tick(); check_all("R1 minute/hour carry");
    // R2 24-hour midnight
    load(59, 59, 23, 0, 14, 3, 2, 30);
    tick(); check_all("R2 midnight 24h");
    // R3 12-hour transitions
    load(59, 59, 11, 1, 5, 5, 1, 40);
    tick(); rd(2, v); chk("R3 noon 0xB2", v, 8'hB2);
    load(59, 59, 12, 1, 5, 5, 1, 40);
    tick(); rd(2, v); chk("R3 one pm 0xA1", v, 8'hA1);
    load(59, 59, 23, 1, 5, 5, 1, 40);
    tick(); check_all("R3 midnight 12h");
    rd(2, v); chk("R3 midnight 0x92", v, 8'h92);
    // R4 weekday wrap
    load(59, 59, 23, 0, 9, 9, 7, 50);
    tick(); rd(5, v); chk("R4 weekday 7->1", v, 8'h01);
    // R5 30-day month
    load(59, 59, 23, 0, 30, 4, 2, 33);
    tick(); check_all("R5 April end");
    // R6 leap rules
    load(59, 59, 23, 0, 28, 2, 2, 0);
    tick(); rd(3, v); chk("R6 year00 Feb29", v, 8'h29);
    load(59, 59, 23, 0, 28, 2, 2, 1);
    tick(); check_all("R6 year01 Mar1");
    load(59, 59, 23, 0, 29, 2, 2, 96);
    tick(); check_all("R6 year96 Mar1");
    // R7 year wrap
    load(59, 59, 23, 0, 31, 12, 6, 99);
    tick(); check_all("R7 year 99->00");

    // R8 halt
    load(59, 59, 23, 0, 31, 12, 6, 99);
    wr(0, 8'hD9, 0); m_halt = 1;
    tick(); tick(); tick();
    check_all("R8 halted");
    wr(0, 8'h59, 0); m_halt = 0;
    tick(); check_all("R8 resumed");

    // R9 write wins over tick
    load(59, 59, 23, 0, 31, 12, 6, 99);
    wr(1, 8'h30, 1); m_m = 30;
    check_all("R9 write with tick");

    // R10 unused bits
    wr(1, 8'hFF, 0); rd(1, v); chk("R10 minutes mask", v, 8'h7F);
    wr(2, 8'hFF, 0); rd(2, v); chk("R10 hours mask", v, 8'hBF);
    wr(3, 8'hFF, 0); rd(3, v); chk("R10 date mask", v, 8'h3F);
    wr(4, 8'hFF, 0); rd(4, v); chk("R10 month mask", v, 8'h1F);
    wr(5, 8'hFF, 0); rd(5, v); chk("R10 weekday mask", v, 8'h07);

    // R11 gap selector
    load(1, 2, 3, 0, 4, 5, 6, 7);
    wr(7, 8'hAA, 0);
    rd(7, v); chk("R11 gap read", v, 8'h00);
    check_all("R11 gap write ignored");

    // random states, biased toward boundaries
    for (int it = 0; it < 160; it++) begin
      int yr, mo, dt, h, nt;
      bit t12, edge_case;
      yr = $urandom % 100; mo = 1 + $urandom % 12;
      edge_case = ($urandom % 2) == 1;
      dt = edge_case ? mlen(mo, yr) : 1 + $urandom % mlen(mo, yr);
      h = edge_case ? 23 : $urandom % 24;
      t12 = ($urandom % 2) == 1;
      load(edge_case ? 59 : $urandom % 60, edge_case ? 59 : $urandom % 60,
           h, t12, dt, mo, 1 + $urandom % 7, yr);
      nt = 1 + $urandom % 2;
      for (int k = 0; k < nt; k++) tick();
      check_all("R1-R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule